// File: doc/BRIEF.md
# Serial EEPROM Host Sequencer

This block drives a three-wire serial EEPROM (chip select, serial clock, serial data in, serial data out) on behalf of a parallel command port. The user presents a command code, a word address and write data and pulses a start strobe. The block then serialises the command frame, collects read data, and for commands that program the array runs the status handshake on its own. That handshake is a chip-select low gap, then a poll of the data-out line until the memory reports ready, then a one-clock start bit that clears the ready indication. When the block finishes it gives a one-cycle done pulse, with the read word and an error flag alongside.

The serial clock is the system clock divided by a parameter. The word organisation (16-bit words with 6 address bits, or 8-bit words with 7 address bits) is chosen by a parameter. The address and data ports follow that choice in width. An optional mode locks the memory again after every programming command by sending a write-disable frame before done. A poll counter bounds the wait for ready and reports a timeout through the error flag.

Top module: `see_host`

## Requirements
- R1: Command codes on `cmd_op`: 0 read, 1 write word, 2 write all, 3 erase word, 4 erase all, 5 unlock, 6 lock (7 acts as lock). Each frame sends a 1 start bit, then an opcode pair, then the address field MSB first, then write data MSB first. The opcode pair is 10 for read, 01 for write word and 11 for erase word. The other commands send 00 and put a selector in the top two address bits: 11 unlock, 10 erase all, 01 write all, 00 lock. The rest of that address field is zero.
- R2: Frame length in serial clocks. With 16-bit words it is 25 for read, write word and write all, and 9 for the others. With 8-bit words it is 18 and 10.
- R3: Chip select rises only while the serial clock is low, and the serial clock is high only while chip select is high.
- R4: The data-in line changes only while the serial clock is low. Each serial clock high phase and each low phase between clocks of one frame lasts CLK_DIV system clocks.
- R5: On read, the dummy zero that follows the last address bit is skipped. One data bit is taken from data-out at the end of the high phase of each of the next DW clocks, MSB first, and the word appears on `rd_data` at done.
- R6: After a programming command (codes 1 to 4), chip select stays low for CSL_GAP system clocks. It is then raised and data-out is polled, low meaning busy and high meaning ready.
- R7: Once data-out reads ready, one serial clock is sent with data-in at 1, and then chip select drops.
- R8: With AUTO_LOCK set, every programming command is followed, after another CSL_GAP low gap, by a lock frame before done. A later write with no unlock then leaves memory unchanged.
- R9: If data-out stays low for POLL_LIMIT system clocks of polling, chip select drops and no clear clock is sent. Done pulses with `err` at 1, and `err` holds until the next accepted start.
- R10: `done` is a one-cycle pulse. `busy` is high from acceptance to done. A start strobe while busy is ignored.
- R11: In reset, chip select, serial clock, data-in, busy, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe, taken while idle |
| cmd_op | input | 3 | Command code (R1) |
| cmd_addr | input | AW | Word address (6 or 7 bits) |
| cmd_wdata | input | DW | Write data (16 or 8 bits) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready poll timed out |
| rd_data | output | DW | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to memory |
| ee_do | input | 1 | Serial data from memory |

## Verification
The bench models the memory at its pins. It decodes every chip-select window into a command and a clock count, and keeps its own expected copy of the array. One corner case is a write to a locked memory. Another is a write right after the automatic lock, where a block that forgot the lock frame would alter the word. A start strobe in the middle of a write must be ignored; a block that took it would emit an extra erase-all frame. A memory stuck busy must raise the error flag with no clear clock; a design that mishandled it would hang or send a stray start. Each frame is checked for a clock edge at chip-select rise and for data moving while the clock is high. The width of each clock phase and the gap before polling are also measured.

// File: rtl/see_pkg.sv
package see_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_FILL   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_WIPE   = 3'd4,
        OP_UNLOCK = 3'd5,
        OP_LOCK   = 3'd6,
        OP_RSVD   = 3'd7
    } see_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SHIFT = 3'd1,
        S_GAP   = 3'd2,
        S_POLL  = 3'd3,
        S_CLR   = 3'd4
    } see_seq_e;

    function automatic logic [1:0] opcode_of(see_op_e op);
        case (op)
            OP_READ:  return 2'b10;
            OP_WRITE: return 2'b01;
            OP_ERASE: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] selector_of(see_op_e op);
        case (op)
            OP_UNLOCK: return 2'b11;
            OP_WIPE:   return 2'b10;
            OP_FILL:   return 2'b01;
            default:   return 2'b00;
        endcase
    endfunction

    function automatic logic carries_addr(see_op_e op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_ERASE);
    endfunction

    function automatic logic carries_data(see_op_e op);
        return (op == OP_WRITE) || (op == OP_FILL);
    endfunction

    function automatic logic programs(see_op_e op);
        return (op == OP_WRITE) || (op == OP_FILL) || (op == OP_ERASE) || (op == OP_WIPE);
    endfunction

endpackage

// File: rtl/see_frame_fmt.sv
module see_frame_fmt
    import see_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int FW = 3 + AW + DW,
    parameter int LW = $clog2(FW + 1)
) (
    input  logic [2:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [FW-1:0] frame,
    output logic [LW-1:0] len
);
    see_op_e       kind;
    logic [AW-1:0] afield;
    logic [DW-1:0] dfield;

    always_comb begin
        kind = see_op_e'(op);
        if (carries_addr(kind)) begin
            afield = addr;
        end else begin
            afield = {selector_of(kind), {(AW-2){1'b0}}};
        end
        dfield = carries_data(kind) ? wdata : '0;
        frame  = {1'b1, opcode_of(kind), afield, dfield};
        if (carries_data(kind) || kind == OP_READ) begin
            len = LW'(FW);
        end else begin
            len = LW'(3 + AW);
        end
    end
endmodule

// File: rtl/see_sk_phase.sv
module see_sk_phase #(
    parameter int DIV = 4,
    parameter int CW  = $clog2(DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DIV));
endmodule

// File: rtl/see_host.sv
module see_host
    import see_pkg::*;
#(
    parameter bit WIDE16     = 1'b1,
    parameter int CLK_DIV    = 50,
    parameter int CSL_GAP    = 64,
    parameter int POLL_LIMIT = 2_000_000,
    parameter bit AUTO_LOCK  = 1'b1,
    localparam int AW = WIDE16 ? 6 : 7,
    localparam int DW = WIDE16 ? 16 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    input  logic          ee_do
);
    localparam int FW   = 3 + AW + DW;
    localparam int LW   = $clog2(FW + 1);
    localparam int TMAX = (POLL_LIMIT > CSL_GAP) ? POLL_LIMIT : CSL_GAP;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        see_seq_e      st;
        logic          cs;
        logic          sk;
        logic          di;
        logic [FW-1:0] sh;
        logic [LW-1:0] left;
        logic [DW-1:0] rd;
        logic [TW-1:0] tmr;
        logic          is_rd;
        logic          is_prog;
        logic          lock_go;
        logic          done;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]    fmt_op;
    logic [FW-1:0] fmt_frame;
    logic [LW-1:0] fmt_len;
    logic          tick;
    logic          run;
    see_op_e       new_op;

    assign fmt_op = (r_q.st == S_IDLE) ? cmd_op : 3'(OP_LOCK);
    assign run    = (r_q.st == S_SHIFT) || (r_q.st == S_CLR);
    assign new_op = see_op_e'(cmd_op);

    see_frame_fmt #(.AW(AW), .DW(DW), .FW(FW), .LW(LW)) u_fmt (
        .op    (fmt_op),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .frame (fmt_frame),
        .len   (fmt_len)
    );

    see_sk_phase #(.DIV(CLK_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_start) begin
                    r_d.st      = S_SHIFT;
                    r_d.cs      = 1'b1;
                    r_d.sk      = 1'b0;
                    r_d.di      = fmt_frame[FW-1];
                    r_d.sh      = fmt_frame << 1;
                    r_d.left    = fmt_len;
                    r_d.is_rd   = (new_op == OP_READ);
                    r_d.is_prog = programs(new_op);
                    r_d.lock_go = 1'b0;
                    r_d.err     = 1'b0;
                    r_d.tmr     = '0;
                end
            end
            S_SHIFT: begin
                if (tick) begin
                    if (!r_q.sk) begin
                        r_d.sk = 1'b1;
                    end else begin
                        r_d.sk = 1'b0;
                        if (r_q.is_rd && r_q.left <= LW'(DW)) begin
                            r_d.rd = {r_q.rd[DW-2:0], ee_do};
                        end
                        if (r_q.left == LW'(1)) begin
                            r_d.cs  = 1'b0;
                            r_d.di  = 1'b0;
                            r_d.tmr = '0;
                            if (r_q.is_prog) begin
                                r_d.st = S_GAP;
                            end else begin
                                r_d.st   = S_IDLE;
                                r_d.done = 1'b1;
                            end
                        end else begin
                            r_d.left = r_q.left - 1'b1;
                            r_d.di   = r_q.sh[FW-1];
                            r_d.sh   = r_q.sh << 1;
                        end
                    end
                end
            end
            S_GAP: begin
                if (r_q.tmr == TW'(CSL_GAP - 1)) begin
                    r_d.tmr = '0;
                    r_d.cs  = 1'b1;
                    if (r_q.lock_go) begin
                        r_d.st      = S_SHIFT;
                        r_d.di      = fmt_frame[FW-1];
                        r_d.sh      = fmt_frame << 1;
                        r_d.left    = fmt_len;
                        r_d.is_rd   = 1'b0;
                        r_d.is_prog = 1'b0;
                        r_d.lock_go = 1'b0;
                    end else begin
                        r_d.st = S_POLL;
                    end
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            S_POLL: begin
                if (ee_do) begin
                    r_d.st = S_CLR;
                    r_d.di = 1'b1;
                end else if (r_q.tmr == TW'(POLL_LIMIT - 1)) begin
                    r_d.cs   = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            S_CLR: begin
                if (tick) begin
                    if (!r_q.sk) begin
                        r_d.sk = 1'b1;
                    end else begin
                        r_d.sk  = 1'b0;
                        r_d.cs  = 1'b0;
                        r_d.di  = 1'b0;
                        r_d.tmr = '0;
                        if (AUTO_LOCK) begin
                            r_d.st      = S_GAP;
                            r_d.lock_go = 1'b1;
                        end else begin
                            r_d.st   = S_IDLE;
                            r_d.done = 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != S_IDLE);
    assign done    = r_q.done;
    assign err     = r_q.err;
    assign rd_data = r_q.rd;
    assign ee_cs   = r_q.cs;
    assign ee_sk   = r_q.sk;
    assign ee_di   = r_q.di;

    assert_cs_rise_sk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk);
    assert_sk_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    assert_di_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tb_see_host.sv
module tb_see_host;
    localparam int AW = 6, DW = 16, DIV = 2, GAP = 64, PLIM = 1500, BUSY_T = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cmd_start = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, done, err, ee_cs, ee_sk, ee_di;
    logic [DW-1:0] rd_data;
    logic          do_r = 1'b0;
    logic          stuck = 1'b0;

    see_host #(.WIDE16(1'b1), .CLK_DIV(DIV), .CSL_GAP(GAP), .POLL_LIMIT(PLIM),
               .AUTO_LOCK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(do_r));

    int checks = 0, fails = 0, m_checks = 0, m_fails = 0;
    int got_q[$];
    int exp_q[$];
    int got_idx = 0;
    logic [DW-1:0] shadow [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
        m_checks++;
        if (!ok) begin
            m_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory model at the pins, evaluated every clock.
    logic [DW-1:0] mem [64];
    logic pcs, psk, pdi, pstuck, started, reading, en, stat, gap_chk;
    int nb, rclk, rk, busy_cnt, lo_cnt, run_len, pend_op, code;
    logic [1:0] hop;
    logic [AW-1:0] ha, ra, pend_addr;
    logic [DW-1:0] dbits, pend_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = '1;
            pcs = 0; psk = 0; pdi = 0; pstuck = 0; started = 0; reading = 0;
            en = 0; stat = 0; gap_chk = 0; nb = 0; rclk = 0; rk = 0;
            busy_cnt = 0; lo_cnt = 0; run_len = 0; pend_op = 0;
            hop = 0; ha = 0; ra = 0; dbits = 0; do_r = 0;
        end else begin
            if (pstuck && !stuck) begin
                busy_cnt = 0; stat = 0;
            end else if (busy_cnt > 0 && !stuck) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    case (pend_op)
                        1: mem[pend_addr] = pend_data;
                        2: for (int i = 0; i < 64; i++) mem[i] = pend_data;
                        3: mem[pend_addr] = '1;
                        4: for (int i = 0; i < 64; i++) mem[i] = '1;
                        default: ;
                    endcase
                end
            end
            if (ee_cs && !pcs) begin
                mchk(!ee_sk, "R3", "clock high at select rise", ee_sk, 0);
                if (gap_chk) begin
                    mchk(lo_cnt >= GAP, "R6", "select low gap", lo_cnt, GAP);
                    gap_chk = 0;
                end
                started = 0; nb = 0; rclk = 0; reading = 0;
            end
            if (ee_sk && !ee_cs) mchk(0, "R3", "clock without select", 1, 0);
            if (ee_cs && ee_sk && psk)
                mchk(ee_di == pdi, "R4", "data moved while clock high", ee_di, pdi);
            if (ee_cs && !ee_sk && psk)
                mchk(run_len == DIV, "R4", "clock high phase", run_len, DIV);
            if (ee_cs && ee_sk && !psk) begin
                if (rclk > 0) mchk(run_len == DIV, "R4", "clock low phase", run_len, DIV);
                rclk++;
                if (!started) begin
                    if (ee_di) begin
                        started = 1;
                        if (busy_cnt == 0) stat = 0;
                    end
                end else if (reading) begin
                    do_r = (rk < DW) ? mem[ra][DW-1-rk] : 1'b0;
                    rk++;
                end else begin
                    if (nb < 2) hop = {hop[0], ee_di};
                    else if (nb < 2 + AW) ha = {ha[AW-2:0], ee_di};
                    else dbits = {dbits[DW-2:0], ee_di};
                    nb++;
                    if (nb == 2 + AW && hop == 2'b10) begin
                        reading = 1; ra = ha; rk = 0; do_r = 0;
                    end
                end
            end
            if (!ee_cs && pcs) begin
                if (!started || (nb == 0 && !reading)) code = 7;
                else if (nb < 2 + AW) code = 8;
                else begin
                    case (hop)
                        2'b10: code = 0;
                        2'b01: code = 1;
                        2'b11: code = 3;
                        default: code = (ha[AW-1:AW-2] == 2'b11) ? 5 :
                                        (ha[AW-1:AW-2] == 2'b10) ? 4 :
                                        (ha[AW-1:AW-2] == 2'b01) ? 2 : 6;
                    endcase
                end
                got_q.push_back(code * 100 + rclk);
                if (code == 5) en = 1;
                if (code == 6) en = 0;
                if ((code == 3 || code == 4) ||
                    ((code == 1 || code == 2) && nb == 2 + AW + DW)) begin
                    gap_chk = 1; stat = 1;
                    if (en) begin
                        busy_cnt = BUSY_T; pend_op = code;
                        pend_addr = ha; pend_data = dbits;
                    end
                end
                reading = 0;
            end
            if (!reading) do_r = (ee_cs && stat) ? (busy_cnt == 0) : 1'b0;
            if (ee_sk != psk) run_len = 1; else run_len++;
            if (!ee_cs) lo_cnt++; else lo_cnt = 0;
            pcs = ee_cs; psk = ee_sk; pdi = ee_di; pstuck = stuck;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + m_checks + 1,
                     fails + m_fails + 1);
            $finish;
        end
    end

    task automatic ex(input int c, input int l);
        exp_q.push_back(c * 100 + l);
    endtask

    task automatic frames(input string req);
        repeat (3) @(negedge clk);
        foreach (exp_q[i]) begin
            int g;
            g = (got_idx < got_q.size()) ? got_q[got_idx] : -1;
            got_idx++;
            chk(g == exp_q[i], req, "frame code*100+clocks", g, exp_q[i]);
        end
        chk(got_idx == got_q.size(), req, "frame count", got_q.size(), got_idx);
        got_idx = got_q.size();
        exp_q.delete();
    endtask

    task automatic run_cmd(input int op, input int addr, input int data, input bit poke,
                           output logic [DW-1:0] rd, output logic er);
        int n;
        @(negedge clk);
        cmd_op = 3'(op); cmd_addr = AW'(addr); cmd_wdata = DW'(data); cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        n = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (poke && n == 20) begin cmd_op = 3'd4; cmd_start = 1; end
            else cmd_start = 0;
        end
        rd = rd_data; er = err;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", done, 0);
        chk(busy == 1'b0, "R10", "idle after done", busy, 0);
    endtask

    task automatic prog_frames(input int c, input int l, input string req);
        ex(c, l); ex(7, 1); ex(6, 9);
        frames(req);
    endtask

    task automatic unlock();
        logic [DW-1:0] rd; logic er;
        run_cmd(5, 0, 0, 0, rd, er);
        ex(5, 9); frames("R1");
    endtask

    task automatic read_chk(input int addr, input string req);
        logic [DW-1:0] rd; logic er;
        run_cmd(0, addr, 0, 0, rd, er);
        chk(rd == shadow[addr], req, "read word", rd, shadow[addr]);
        chk(er == 1'b0, req, "no error on read", er, 0);
        ex(0, 25); frames("R2");
    endtask

    initial begin
        logic [DW-1:0] rd; logic er;
        for (int i = 0; i < 64; i++) shadow[i] = '1;
        repeat (4) @(negedge clk);
        chk(ee_cs == 0 && ee_sk == 0 && ee_di == 0, "R11", "pins in reset",
            {ee_cs, ee_sk, ee_di}, 0);
        chk(busy == 0 && done == 0 && err == 0, "R11", "status in reset",
            {busy, done, err}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R8: memory starts locked; write is ignored
        run_cmd(1, 5, 16'hA5C3, 0, rd, er);
        chk(er == 0, "R6", "locked write completes", er, 0);
        prog_frames(1, 25, "R7");
        read_chk(5, "R5");

        // R6 R7 R8 R10: enabled write with a stray start mid-command
        unlock();
        run_cmd(1, 5, 16'hA5C3, 1, rd, er);
        shadow[5] = 16'hA5C3;
        prog_frames(1, 25, "R10");
        read_chk(5, "R5");

        // R8: the automatic lock blocks the next write
        run_cmd(1, 5, 16'h1111, 0, rd, er);
        prog_frames(1, 25, "R8");
        read_chk(5, "R8");

        // R1: top address with MSB set
        unlock();
        run_cmd(1, 63, 16'h8001, 0, rd, er);
        shadow[63] = 16'h8001;
        prog_frames(1, 25, "R1");
        read_chk(63, "R1");
        read_chk(0, "R1");

        // R2: short frame erase
        unlock();
        run_cmd(3, 5, 0, 0, rd, er);
        shadow[5] = '1;
        prog_frames(3, 9, "R2");
        read_chk(5, "R2");

        // R1: write all
        unlock();
        run_cmd(2, 0, 16'h3C5A, 0, rd, er);
        for (int i = 0; i < 64; i++) shadow[i] = 16'h3C5A;
        prog_frames(2, 25, "R1");
        read_chk(0, "R1");
        read_chk(63, "R5");

        // R1: erase all
        unlock();
        run_cmd(4, 0, 0, 0, rd, er);
        for (int i = 0; i < 64; i++) shadow[i] = '1;
        prog_frames(4, 9, "R2");
        read_chk(17, "R5");

        // R9: memory never reports ready
        unlock();
        stuck = 1;
        run_cmd(1, 9, 16'h7777, 0, rd, er);
        chk(er == 1'b1, "R9", "timeout flag at done", er, 1);
        ex(1, 25); ex(7, 0); frames("R9");
        repeat (10) @(negedge clk);
        chk(err == 1'b1, "R9", "flag holds while idle", err, 1);
        chk(ee_cs == 1'b0, "R9", "select low after timeout", ee_cs, 0);
        stuck = 0;
        repeat (2) @(negedge clk);
        read_chk(9, "R9");
        chk(err == 1'b0, "R9", "flag cleared by next start", err, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks + m_checks, fails + m_fails);
        $finish;
    end
endmodule